// File: doc/BRIEF.md
# Thermostat Alarm Output Controller

This block watches a stream of signed temperature results and drives one thermostat output pin. Each result arrives with a one-cycle valid strobe. The block compares it against a programmable upper threshold and a programmable lower threshold, and the pin changes on the clock edge that takes the result.

Two behaviours are available. Comparator mode is a plain alarm with hysteresis. Interrupt mode latches each event until the host acknowledges it with a clear strobe. It also alternates strictly between an upper event and a lower event.

A polarity input chooses whether the pin is active-high or active-low. The sensor, the serial host interface and the threshold storage live outside this block.

Top module: `thermo_alarm`

## Requirements
- R1: After reset the output is inactive, and interrupt mode first waits for an upper event.
- R2: In comparator mode (mode_irq=0), a valid sample at or above thr_hi makes the output active on the clock edge that takes the sample. A sample one below thr_hi does not make it active.
- R3: In comparator mode, an active output stays active while valid samples lie at or above thr_lo. It goes inactive on the edge that takes a valid sample below thr_lo. An inactive output stays inactive for samples between the thresholds.
- R4: In interrupt mode (mode_irq=1), a valid sample at or above thr_hi makes an inactive output active, provided the block is waiting for an upper event. The output then stays active for any later samples until a clear arrives.
- R5: In interrupt mode, a cleared upper event is followed only by a lower event. The next event is a valid sample below thr_lo, and samples at or above thr_hi do not fire. A cleared lower event is in turn followed only by an upper event.
- R6: In interrupt mode, clr_evt makes an active output inactive on the next edge. A clear while the output is inactive has no effect, and a clear in comparator mode has no effect.
- R7: Samples and thresholds are compared as two's-complement signed values, so 16'h8000 is the most negative temperature.
- R8: With pol_high=1 the pin is high when the output is active. With pol_high=0 the pin is low when the output is active. The polarity acts on the pin at once, without waiting for a clock edge.
- R9: A sample presented with temp_vld=0 changes nothing.
- R10: A change of mode_irq makes the output inactive on the next edge, and interrupt mode then waits for an upper event.
- R11: In interrupt mode, when clr_evt and a valid sample arrive together while the output is active, the clear wins. That sample is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| temp_in | input | TW | Signed temperature sample |
| temp_vld | input | 1 | Sample valid strobe |
| thr_hi | input | TW | Signed upper threshold |
| thr_lo | input | TW | Signed lower threshold |
| mode_irq | input | 1 | 0 selects comparator mode, 1 selects interrupt mode |
| pol_high | input | 1 | 1 makes the pin active-high, 0 makes it active-low |
| clr_evt | input | 1 | Event acknowledge strobe |
| alarm_pin | output | 1 | Thermostat output pin |

## Verification
Comparator mode is driven with samples that rise through the upper threshold, settle between the thresholds and then drop below the lower one. These tell hysteresis apart from a single-threshold compare, and one-below-threshold values locate both boundaries exactly. Negative thresholds and the most negative code separate a signed compare from an unsigned one.

Interrupt mode is driven with repeated upper samples, opposite-side samples and clears given alone or together with a sample. These show that events latch, that they alternate strictly, and that a clear takes priority. Changes of polarity and of mode, and samples held with the strobe low, show that the pin level and the event state change only through the defined paths.

// File: rtl/thermo_alarm.sv
module thermo_alarm #(
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [TW-1:0] temp_in,
  input  logic                 temp_vld,
  input  logic signed [TW-1:0] thr_hi,
  input  logic signed [TW-1:0] thr_lo,
  input  logic                 mode_irq,
  input  logic                 pol_high,
  input  logic                 clr_evt,
  output logic                 alarm_pin
);

  logic act_q;
  logic hunt_lo_q;
  logic mode_q;

  logic at_hi, below_lo, mode_chg;

  assign at_hi    = temp_in >= thr_hi;
  assign below_lo = temp_in < thr_lo;
  assign mode_chg = mode_irq != mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      hunt_lo_q <= 1'b0;
      mode_q    <= 1'b0;
    end else begin
      mode_q <= mode_irq;
      if (mode_chg) begin
        act_q     <= 1'b0;
        hunt_lo_q <= 1'b0;
      end else if (!mode_irq) begin
        if (temp_vld) begin
          if (at_hi)         act_q <= 1'b1;
          else if (below_lo) act_q <= 1'b0;
        end
      end else if (act_q) begin
        if (clr_evt) act_q <= 1'b0;
      end else if (temp_vld) begin
        if (!hunt_lo_q && at_hi) begin
          act_q     <= 1'b1;
          hunt_lo_q <= 1'b1;
        end else if (hunt_lo_q && below_lo) begin
          act_q     <= 1'b1;
          hunt_lo_q <= 1'b0;
        end
      end
    end
  end

  assign alarm_pin = pol_high ? act_q : ~act_q;

endmodule

// File: rtl/thermo_alarm_chk.sv
module thermo_alarm_chk #(
  parameter int TW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic signed [TW-1:0] temp_in,
  input logic                 temp_vld,
  input logic signed [TW-1:0] thr_hi,
  input logic signed [TW-1:0] thr_lo,
  input logic                 mode_irq,
  input logic                 clr_evt,
  input logic                 act,
  input logic                 hunt,
  input logic                 mode_q
);

  // R2
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_irq && !mode_q && temp_vld && temp_in >= thr_hi) |=> act);

  // R3
  cmp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_irq && !mode_q && temp_vld && temp_in < thr_lo && temp_in < thr_hi) |=> !act);

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_irq && mode_q && act && !clr_evt) |=> act);

  // R5
  irq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_irq && mode_q && !act && hunt && !(temp_vld && temp_in < thr_lo)) |=> !act);

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_irq && act && clr_evt) |=> !act);

  // R9
  no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!temp_vld && !clr_evt && mode_irq == mode_q) |=> ($stable(act) && $stable(hunt)));

  // R10
  mode_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_irq != mode_q) |=> (!act && !hunt));

endmodule

bind thermo_alarm thermo_alarm_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .temp_vld(temp_vld),
  .thr_hi(thr_hi), .thr_lo(thr_lo), .mode_irq(mode_irq), .clr_evt(clr_evt),
  .act(act_q), .hunt(hunt_lo_q), .mode_q(mode_q)
);

// File: tb/test_thermo_alarm.sv
module test_thermo_alarm;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [TW-1:0] temp_in = '0;
  logic temp_vld = 1'b0;
  logic signed [TW-1:0] thr_hi = 16'sd100;
  logic signed [TW-1:0] thr_lo = 16'sd50;
  logic mode_irq = 1'b0;
  logic pol_high = 1'b1;
  logic clr_evt = 1'b0;
  logic alarm_pin;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bit    q_exp[$];
  string q_tag[$];

  bit m_act = 1'b0, m_hunt = 1'b0, m_mode = 1'b0;

  always #10 clk = ~clk;

  thermo_alarm #(.TW(TW)) i_thermo_alarm (
    .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .temp_vld(temp_vld),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .mode_irq(mode_irq), .pol_high(pol_high),
    .clr_evt(clr_evt), .alarm_pin(alarm_pin)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: alarm_pin=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic signed [TW-1:0] t, input bit vld, input bit clr,
                      input bit mode, input bit pol, input string tag);
    @(negedge clk);
    temp_in = t; temp_vld = vld; clr_evt = clr; mode_irq = mode; pol_high = pol;
    if (mode != m_mode) begin
      m_act = 0; m_hunt = 0;
    end else if (!mode) begin
      if (vld) begin
        if (t >= thr_hi) m_act = 1;
        else if (t < thr_lo) m_act = 0;
      end
    end else if (m_act) begin
      if (clr) m_act = 0;
    end else if (vld) begin
      if (!m_hunt && t >= thr_hi) begin m_act = 1; m_hunt = 1; end
      else if (m_hunt && t < thr_lo) begin m_act = 1; m_hunt = 0; end
    end
    m_mode = mode;
    @(posedge clk);
    #1;
    q_exp.push_back(pol ? m_act : !m_act);
    q_tag.push_back(tag);
  endtask

  always begin
    @(posedge clk);
    #5;
    if (q_exp.size() > 0) check(alarm_pin, q_exp.pop_front(), q_tag.pop_front());
  end

  initial begin
    #5;
    check(alarm_pin, 1'b0, "R1 reset pin");
    #30 rst_n = 1'b1;
    // comparator mode, hi=100 lo=50
    step(16'sd40, 1, 0, 0, 1, "R3 below both stays off");
    step(16'sd99, 1, 0, 0, 1, "R2 one below hi");
    step(16'sd100, 1, 0, 0, 1, "R2 at hi");
    step(16'sd70, 1, 0, 0, 1, "R3 hold between");
    step(16'sd50, 1, 0, 0, 1, "R3 at lo holds");
    step(16'sd0, 0, 0, 0, 1, "R9 no valid");
    step(16'sd49, 1, 1, 0, 1, "R3 below lo, R6 clr ignored in cmp");
    step(16'sd300, 0, 0, 0, 1, "R9 high sample no valid");
    step(16'sd70, 1, 0, 0, 1, "R3 between stays off");
    // signed thresholds
    @(negedge clk); thr_hi = -16'sd10; thr_lo = -16'sd30;
    step(-16'sd5, 1, 0, 0, 1, "R7 negative at hi side");
    step(-16'sd20, 1, 0, 0, 1, "R7 hold between negatives");
    step(-16'sd20, 1, 0, 0, 0, "R8 active-low pin");
    step(-16'sd20, 0, 0, 0, 1, "R8 active-high pin");
    step(16'sh8000, 1, 0, 0, 1, "R7 most negative releases");
    step(16'sh7FFF, 1, 0, 0, 1, "R7 most positive sets");
    // mode change
    step(16'sd0, 0, 0, 1, 1, "R10 mode change clears");
    @(negedge clk); thr_hi = 16'sd100; thr_lo = 16'sd50;
    step(16'sd20, 1, 0, 1, 1, "R1 irq waits for upper");
    step(16'sd0, 0, 1, 1, 1, "R6 clr while inactive");
    step(16'sd120, 1, 0, 1, 1, "R4 upper event");
    step(16'sd10, 1, 0, 1, 1, "R4 held on low sample");
    step(16'sd10, 1, 0, 1, 0, "R8 active-low in irq");
    step(16'sd70, 0, 1, 1, 1, "R6 clear releases");
    step(16'sd150, 1, 0, 1, 1, "R5 upper after upper ignored");
    step(16'sd40, 1, 0, 1, 1, "R5 lower event");
    step(16'sd200, 1, 1, 1, 1, "R11 clear wins over sample");
    step(16'sd20, 1, 0, 1, 1, "R5 lower after lower ignored");
    step(16'sd200, 1, 0, 1, 1, "R5 upper follows lower");
    step(16'sd0, 0, 0, 0, 1, "R10 back to comparator");
    step(16'sd70, 1, 0, 0, 1, "R10 state cleared");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule